// File: doc/BRIEF.md
# Multi-Step Square Root Unit for GF(2^193)

This unit takes an element of the binary field GF(2^193), held in polynomial basis and reduced by x^193 + x^15 + 1, and returns its 2^n-th root for a chosen n in one clock cycle. Because the field has characteristic two, the square root is linear. When the field degree and the middle exponent of the trinomial are both odd, it reduces to one level of XOR gates: the even-indexed coefficients shifted down, plus the odd-indexed coefficients multiplied by sqrt(x) = x^97 + x^8.

Twelve copies of that single-root network are cascaded. The outputs after 1, 2, 3, 6 and 12 copies feed a five-way selector. An inverter's control sequencer picks the root count it needs for each step. It obtains larger counts by feeding the registered result back to the operand input over several cycles. The selected value is registered, and the register has a synchronous reset.

There are no states. The data path is purely combinational up to the single output register, so the reset and layout conventions apply, but no sequencer is modelled.

Top module: `gfroot_multi`

## Requirements
- R1: With select code 000, the output is the single square root of the operand, meaning that squaring the output modulo x^193 + x^15 + 1 returns the operand.
- R2: With select code 001, the output is the operand's root taken twice, so squaring it twice returns the operand.
- R3: With select code 010, the output is the operand's root taken three times.
- R4: With select code 011, the output is the operand's root taken six times.
- R5: With select code 100, the output is the operand's root taken twelve times.
- R6: With select codes 101, 110 and 111, the output equals the operand unchanged.
- R7: The output updates only at a rising clock edge and reflects the operand and select sampled at that edge. A change of inputs between edges does not alter the output.
- R8: While rst_n is low at a rising edge, the output becomes all zeros. Lowering rst_n between edges leaves the output unchanged until the next edge.
- R9: For every select code, an all-zero operand gives an all-zero output, and the operand 1 (bit 0 only) gives 1.
- R10: A single root maps x (only bit 1 set) to x^97 + x^8 (bits 97 and 8 set), and maps x^192 (only bit 192 set) to x^96 (only bit 96 set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| operand_i | input | 193 | Field element, bit i is the coefficient of x^i |
| sel_i | input | 3 | Root count select: 000=1, 001=2, 010=3, 011=6, 100=12, others pass-through |
| root_o | output | 193 | Registered result |

## Verification
The bench never predicts root bits directly. It squares the registered result as many times as the select code asks and compares the result to the operand. A wrong XOR tap or a mis-wired tap point therefore fails on random operands. The basis elements x and x^192 probe both ends of the closed form, where a design that dropped the wrap-around term or the low shift would return a single bit or the wrong pair. The pass-through codes and the all-zero and all-one operands catch a selector that decodes unused codes into a root. A check between clock edges catches an output that follows its inputs combinationally or a reset that acts asynchronously.

// File: rtl/gfroot_pkg.sv
`timescale 1ns/1ps
package gfroot_pkg;
    // Field degree and middle exponent of the reduction trinomial
    localparam int FIELD_M = 193;
    localparam int TRI_K   = 15;
    localparam int SEL_W   = 3;

    // Root counts available at the selector taps
    localparam int TAP_A = 1;
    localparam int TAP_B = 2;
    localparam int TAP_C = 3;
    localparam int TAP_D = 6;
    localparam int TAP_E = 12;
    localparam int CHAIN_LEN = TAP_E;

    typedef enum logic [SEL_W-1:0] {
        SEL_ROOT1  = 3'b000,
        SEL_ROOT2  = 3'b001,
        SEL_ROOT3  = 3'b010,
        SEL_ROOT6  = 3'b011,
        SEL_ROOT12 = 3'b100,
        SEL_PASS5  = 3'b101,
        SEL_PASS6  = 3'b110,
        SEL_PASS7  = 3'b111
    } root_sel_e;
endpackage

// File: rtl/gfroot_stage.sv
`timescale 1ns/1ps
// One square root over a trinomial field with odd degree and odd middle term:
// sqrt(a) = even(a) + odd(a) * (x^((M+1)/2) + x^((K+1)/2)); no reduction needed.
module gfroot_stage #(
    parameter int M = 193,
    parameter int K = 15
) (
    input  logic [M-1:0] a_i,
    output logic [M-1:0] d_o
);
    localparam int HI_SH = (M + 1) / 2;
    localparam int LO_SH = (K + 1) / 2;

    logic [M-1:0] ev_t;
    logic [M-1:0] hi_t;
    logic [M-1:0] lo_t;

    for (genvar i = 0; i < M; i++) begin : g_bit
        if (2 * i < M) begin : g_ev
            assign ev_t[i] = a_i[2*i];
        end else begin : g_ev0
            assign ev_t[i] = 1'b0;
        end

        if (i >= HI_SH) begin : g_hi
            if (2 * (i - HI_SH) + 1 < M) begin : g_hv
                assign hi_t[i] = a_i[2*(i-HI_SH)+1];
            end else begin : g_hz
                assign hi_t[i] = 1'b0;
            end
        end else begin : g_hi0
            assign hi_t[i] = 1'b0;
        end

        if (i >= LO_SH) begin : g_lo
            if (2 * (i - LO_SH) + 1 < M) begin : g_lv
                assign lo_t[i] = a_i[2*(i-LO_SH)+1];
            end else begin : g_lz
                assign lo_t[i] = 1'b0;
            end
        end else begin : g_lo0
            assign lo_t[i] = 1'b0;
        end

        assign d_o[i] = ev_t[i] ^ hi_t[i] ^ lo_t[i];
    end
endmodule

// File: rtl/gfroot_chain.sv
`timescale 1ns/1ps
// Cascade of DEPTH single-root stages; every intermediate level is exposed.
module gfroot_chain #(
    parameter int M     = 193,
    parameter int K     = 15,
    parameter int DEPTH = 12
) (
    input  logic [M-1:0]            a_i,
    output logic [DEPTH:0][M-1:0]   lvl_o
);
    assign lvl_o[0] = a_i;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        gfroot_stage #(.M(M), .K(K)) u_stage (
            .a_i (lvl_o[s]),
            .d_o (lvl_o[s+1])
        );
    end
endmodule

// File: rtl/gfroot_mux.sv
`timescale 1ns/1ps
// Five-way tap selector; unused codes pass the operand through.
module gfroot_mux
    import gfroot_pkg::*;
#(
    parameter int M     = 193,
    parameter int DEPTH = CHAIN_LEN
) (
    input  logic [DEPTH:0][M-1:0] lvl_i,
    input  logic [SEL_W-1:0]      sel_i,
    output logic [M-1:0]          y_o
);
    root_sel_e sel_e;
    assign sel_e = root_sel_e'(sel_i);

    always_comb begin
        unique case (sel_e)
            SEL_ROOT1:  y_o = lvl_i[TAP_A];
            SEL_ROOT2:  y_o = lvl_i[TAP_B];
            SEL_ROOT3:  y_o = lvl_i[TAP_C];
            SEL_ROOT6:  y_o = lvl_i[TAP_D];
            SEL_ROOT12: y_o = lvl_i[TAP_E];
            default:    y_o = lvl_i[0];
        endcase
    end
endmodule

// File: rtl/gfroot_multi.sv
`timescale 1ns/1ps
module gfroot_multi
    import gfroot_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FIELD_M-1:0]  operand_i,
    input  logic [SEL_W-1:0]    sel_i,
    output logic [FIELD_M-1:0]  root_o
);
    logic [CHAIN_LEN:0][FIELD_M-1:0] lvl;
    logic [FIELD_M-1:0]              pick;

    gfroot_chain #(.M(FIELD_M), .K(TRI_K), .DEPTH(CHAIN_LEN)) u_chain (
        .a_i   (operand_i),
        .lvl_o (lvl)
    );

    gfroot_mux #(.M(FIELD_M), .DEPTH(CHAIN_LEN)) u_mux (
        .lvl_i (lvl),
        .sel_i (sel_i),
        .y_o   (pick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_o <= '0;
        end else begin
            root_o <= pick;
        end
    end
endmodule

// File: rtl/gfroot_multi_chk.sv
`timescale 1ns/1ps
module gfroot_multi_chk
    import gfroot_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [FIELD_M-1:0]  operand_i,
    input logic [SEL_W-1:0]    sel_i,
    input logic [FIELD_M-1:0]  root_o
);
    localparam int W2 = 2 * FIELD_M - 1;
    localparam logic [FIELD_M-1:0] ONE_E  = FIELD_M'(1);
    localparam logic [FIELD_M-1:0] X_E    = FIELD_M'(1) << 1;
    localparam logic [FIELD_M-1:0] SQX_E  = (FIELD_M'(1) << ((FIELD_M + 1) / 2))
                                          | (FIELD_M'(1) << ((TRI_K + 1) / 2));

    function automatic logic [FIELD_M-1:0] fsq(input logic [FIELD_M-1:0] a);
        logic [W2-1:0] w;
        w = '0;
        for (int j = 0; j < FIELD_M; j++) w[2*j] = a[j];
        for (int j = W2 - 1; j >= FIELD_M; j--) begin
            if (w[j]) begin
                w[j] = 1'b0;
                w[j-FIELD_M] = ~w[j-FIELD_M];
                w[j-FIELD_M+TRI_K] = ~w[j-FIELD_M+TRI_K];
            end
        end
        return w[FIELD_M-1:0];
    endfunction

    AST_ROOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'b000) |=> (fsq(root_o) == $past(operand_i)));          // R1
    AST_ROOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 3'b001) |=> (fsq(fsq(root_o)) == $past(operand_i)));     // R2
    AST_PASS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i > 3'b100) |=> (root_o == $past(operand_i)));                // R6
    AST_ZERO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (operand_i == '0) |=> (root_o == '0));                            // R9
    AST_UNIT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (operand_i == ONE_E) |=> (root_o == ONE_E));                       // R9
    AST_ROOT_OF_X: assert property (@(posedge clk) disable iff (!rst_n)
        (operand_i == X_E && sel_i == 3'b000) |=> (root_o == SQX_E));      // R10
endmodule

bind gfroot_multi gfroot_multi_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .operand_i (operand_i),
    .sel_i     (sel_i),
    .root_o    (root_o)
);

// File: tb/gfroot_multi_tb.sv
`timescale 1ns/1ps
module gfroot_multi_tb;
    localparam int M  = 193;
    localparam int W2 = 2 * M - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [M-1:0] opnd = '0;
    logic [2:0]   sel = 3'b000;
    wire  [M-1:0] root;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gfroot_multi u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .operand_i (opnd),
        .sel_i     (sel),
        .root_o    (root)
    );

    // Squaring modulo x^193 + x^15 + 1
    function automatic logic [M-1:0] sq(input logic [M-1:0] a);
        logic [W2-1:0] w;
        w = '0;
        for (int j = 0; j < M; j++) w[2*j] = a[j];
        for (int j = W2 - 1; j >= M; j--) begin
            if (w[j]) begin
                w[j] = 1'b0;
                w[j-M] = ~w[j-M];
                w[j-M+15] = ~w[j-M+15];
            end
        end
        return w[M-1:0];
    endfunction

    function automatic logic [M-1:0] sqn(input logic [M-1:0] a, input int n);
        logic [M-1:0] r;
        r = a;
        for (int i = 0; i < n; i++) r = sq(r);
        return r;
    endfunction

    function automatic logic [M-1:0] rnd();
        logic [223:0] w;
        w = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        return w[M-1:0];
    endfunction

    task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [M-1:0] op, input logic [2:0] s, output logic [M-1:0] res);
        @(negedge clk);
        opnd = op;
        sel  = s;
        @(negedge clk);
        res = root;
    endtask

    task automatic t_reset();
        logic [M-1:0] r, op;
        rst_n = 1'b0;
        opnd  = rnd();
        sel   = 3'b101;
        repeat (2) @(negedge clk);
        check("R8 reset value", root, '0);
        rst_n = 1'b1;
        op = rnd() | 1;
        apply(op, 3'b101, r);
        check("R8 pre-reset load", r, op);
        rst_n = 1'b0;
        #1;
        check("R8 no async clear", root, op);
        @(negedge clk);
        check("R8 sync clear", root, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_roots();
        logic [M-1:0] r, op;
        int cnt [5] = '{1, 2, 3, 6, 12};
        string tag [5] = '{"R1", "R2", "R3", "R4", "R5"};
        for (int c = 0; c < 5; c++) begin
            for (int k = 0; k < 4; k++) begin
                op = rnd();
                apply(op, 3'(c), r);
                check(tag[c], sqn(r, cnt[c]), op);
            end
        end
    endtask

    task automatic t_pass();
        logic [M-1:0] r, op;
        for (int c = 5; c < 8; c++) begin
            op = rnd();
            apply(op, 3'(c), r);
            check("R6 pass-through", r, op);
        end
    endtask

    task automatic t_special();
        logic [M-1:0] r;
        for (int c = 0; c < 8; c++) begin
            apply('0, 3'(c), r);
            check("R9 zero", r, '0);
            apply(M'(1), 3'(c), r);
            check("R9 one", r, M'(1));
        end
    endtask

    task automatic t_basis();
        logic [M-1:0] r;
        apply(M'(1) << 1, 3'b000, r);
        check("R10 root of x", r, (M'(1) << 97) | (M'(1) << 8));
        apply(M'(1) << 192, 3'b000, r);
        check("R10 root of x^192", r, M'(1) << 96);
    endtask

    task automatic t_latency();
        logic [M-1:0] r, op1, op2;
        op1 = rnd();
        op2 = ~op1;
        apply(op1, 3'b110, r);
        check("R7 first load", r, op1);
        opnd = op2;
        sel  = 3'b000;
        #1;
        check("R7 held between edges", root, op1);
        @(negedge clk);
        check("R7 next edge", sq(root), op2);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_roots();
        t_pass();
        t_special();
        t_basis();
        t_latency();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule